// File: doc/BRIEF.md
# PES Header Flag and Timestamp Filter

This block decides, one PES packet at a time, whether the packet is forwarded. An upstream parser presents the already-extracted header fields in a single cycle: the 8-bit flags byte, the trick-mode byte with a presence bit, the 33-bit presentation and decoding timestamps each with a presence bit, and a bit saying whether the stream is audio/video. Four filters judge the header. Two are masked equality tests, one on the flags byte and one on the trick-mode byte. Two are inclusive min/max windows, one per timestamp. The packet passes only when every filter passes.

The decision is latched when the header arrives. It then governs the payload bytes that follow. A passing audio/video packet is streamed to the decoder port. Any other passing packet is streamed to the buffer port. A failing packet is discarded completely. One cycle after the last byte of a forwarded packet leaves the block, a single-cycle end-of-packet interrupt is raised.

The filter settings are static inputs. They must be held stable while a header is being judged. A header must precede its first payload byte by at least one cycle.

Top module: `pes_hdr_gate`

## Requirements
- R1: The flags filter passes when `((hdr_flags ^ cfg_flag_match) & cfg_flag_mask) == 0`. The bit layout is: [7:6] PTS/DTS presence code, [5] ESCR present, [4] ES rate present, [3] trick mode present, [2] copy info present, [1] CRC present, [0] extension present.
- R2: The trick filter passes when `((hdr_trick ^ cfg_trick_match) & cfg_trick_mask) == 0`, or when `hdr_trick_vld` is 0.
- R3: The PTS filter passes when `cfg_pts_lo <= hdr_pts <= cfg_pts_hi`, compared unsigned over all 33 bits, or when `hdr_pts_vld` is 0.
- R4: The DTS filter passes when `cfg_dts_lo <= hdr_dts <= cfg_dts_hi`, compared unsigned over all 33 bits, or when `hdr_dts_vld` is 0.
- R5: The enable bits are `cfg_en[0]` flags, `cfg_en[1]` trick, `cfg_en[2]` PTS and `cfg_en[3]` DTS. A filter whose enable bit is 0 passes whatever its inputs are.
- R6: The packet decision is the AND of the four filter results. It appears on `hdr_match` in the cycle after `hdr_valid` and holds until the next header.
- R7: When the decision passes and `hdr_is_av` was 1, every payload byte appears on `dec_valid`/`dec_data` exactly one cycle after it is offered. `buf_valid` stays 0 throughout.
- R8: When the decision passes and `hdr_is_av` was 0, every payload byte appears on `buf_valid`/`buf_data` exactly one cycle after it is offered. `dec_valid` stays 0 throughout.
- R9: When the decision fails, no payload byte appears on either output port and `eop_irq` stays 0.
- R10: `eop_irq` pulses for one cycle, in the cycle after a forwarded byte that was offered with `pl_last` = 1 appears on an output port. It pulses at no other time.
- R11: Synchronous active-high reset clears all outputs and sets the decision to fail. Payload offered after reset, before any header, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 4 | Per-filter enables (flags, trick, PTS, DTS) |
| cfg_flag_match | input | 8 | Flags compare value |
| cfg_flag_mask | input | 8 | Flags compare mask, 1 = bit compared |
| cfg_trick_match | input | 8 | Trick-mode compare value |
| cfg_trick_mask | input | 8 | Trick-mode compare mask |
| cfg_pts_lo | input | 33 | PTS window lower bound, inclusive |
| cfg_pts_hi | input | 33 | PTS window upper bound, inclusive |
| cfg_dts_lo | input | 33 | DTS window lower bound, inclusive |
| cfg_dts_hi | input | 33 | DTS window upper bound, inclusive |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| hdr_flags | input | 8 | Header flags byte |
| hdr_trick | input | 8 | Trick-mode byte |
| hdr_trick_vld | input | 1 | Trick-mode byte present |
| hdr_pts | input | 33 | Presentation timestamp |
| hdr_pts_vld | input | 1 | PTS present |
| hdr_dts | input | 33 | Decoding timestamp |
| hdr_dts_vld | input | 1 | DTS present |
| hdr_is_av | input | 1 | Stream is audio/video |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Last payload byte of the packet |
| hdr_match | output | 1 | Latched packet decision |
| dec_valid | output | 1 | Decoder port byte valid |
| dec_data | output | 8 | Decoder port byte |
| buf_valid | output | 1 | Buffer port byte valid |
| buf_data | output | 8 | Buffer port byte |
| eop_irq | output | 1 | End-of-packet interrupt pulse |

## Verification
The bench places timestamps exactly on each window bound and one step outside it. It also uses a window high in the 33-bit range. A design that used exclusive compares, or dropped the top timestamp bit, would then forward or discard the wrong packets. The bench also checks that absent fields and disabled filters pass, and that differences in unmasked flag bits are ignored; a design that judged them would silently lose packets. Back-to-back single-byte packets, and a dropped packet sandwiched between forwarded ones, catch an interrupt that is mistimed, duplicated or raised for a discarded packet. A packet that passes one timestamp window but fails the other catches a design that ORs the filters instead of ANDing them.

// File: rtl/pes_gate_pkg.sv
package pes_gate_pkg;

    localparam int PES_BYTE_W = 8;
    localparam int PES_TS_W   = 33;
    localparam int NUM_FILT   = 4;

    typedef enum logic [1:0] {
        FI_FLAGS = 2'd0,
        FI_TRICK = 2'd1,
        FI_PTS   = 2'd2,
        FI_DTS   = 2'd3
    } filt_idx_e;

    typedef struct packed {
        logic pass;
        logic av;
    } route_dec_t;

    typedef struct packed {
        logic to_dec;
        logic to_buf;
        logic last;
    } beat_ctl_t;

    function automatic logic all_pass(input logic [NUM_FILT-1:0] res);
        return &res;
    endfunction

    function automatic beat_ctl_t steer(input route_dec_t d, input logic vld, input logic last);
        beat_ctl_t b;
        b.to_dec = vld && d.pass && d.av;
        b.to_buf = vld && d.pass && !d.av;
        b.last   = vld && d.pass && last;
        return b;
    endfunction

endpackage

// File: rtl/pes_mask_cmp.sv
module pes_mask_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] field,
    input  logic [W-1:0] match,
    input  logic [W-1:0] mask,
    input  logic         enable,
    input  logic         present,
    output logic         pass
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (field ^ match) & mask;
        pass = !enable || !present || (diff == '0);
    end
endmodule

// File: rtl/pes_range_cmp.sv
module pes_range_cmp #(
    parameter int W = 33
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         enable,
    input  logic         present,
    output logic         pass
);
    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (value >= lo);
        below_hi = (value <= hi);
        pass     = !enable || !present || (above_lo && below_hi);
    end
endmodule

// File: rtl/pes_route.sv
module pes_route
    import pes_gate_pkg::*;
#(
    parameter int DW = PES_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hdr_valid,
    input  logic          hdr_pass,
    input  logic          hdr_av,
    input  logic          pl_valid,
    input  logic [DW-1:0] pl_data,
    input  logic          pl_last,
    output logic          match_q,
    output logic          dec_valid,
    output logic [DW-1:0] dec_data,
    output logic          buf_valid,
    output logic [DW-1:0] buf_data,
    output logic          eop_irq
);
    route_dec_t dec_q;
    beat_ctl_t  beat;
    logic       last_q;

    always_comb begin
        beat = steer(dec_q, pl_valid, pl_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else if (hdr_valid) begin
            dec_q.pass <= hdr_pass;
            dec_q.av   <= hdr_av;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            buf_valid <= 1'b0;
            dec_data  <= '0;
            buf_data  <= '0;
            last_q    <= 1'b0;
            eop_irq   <= 1'b0;
        end else begin
            dec_valid <= beat.to_dec;
            buf_valid <= beat.to_buf;
            if (beat.to_dec) dec_data <= pl_data;
            if (beat.to_buf) buf_data <= pl_data;
            last_q    <= beat.last;
            eop_irq   <= last_q;
        end
    end

    assign match_q = dec_q.pass;
endmodule

// File: rtl/pes_hdr_gate.sv
module pes_hdr_gate
    import pes_gate_pkg::*;
#(
    parameter int FW = PES_BYTE_W,
    parameter int TW = PES_TS_W,
    parameter int DW = PES_BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cfg_en,
    input  logic [FW-1:0] cfg_flag_match,
    input  logic [FW-1:0] cfg_flag_mask,
    input  logic [FW-1:0] cfg_trick_match,
    input  logic [FW-1:0] cfg_trick_mask,
    input  logic [TW-1:0] cfg_pts_lo,
    input  logic [TW-1:0] cfg_pts_hi,
    input  logic [TW-1:0] cfg_dts_lo,
    input  logic [TW-1:0] cfg_dts_hi,
    input  logic          hdr_valid,
    input  logic [FW-1:0] hdr_flags,
    input  logic [FW-1:0] hdr_trick,
    input  logic          hdr_trick_vld,
    input  logic [TW-1:0] hdr_pts,
    input  logic          hdr_pts_vld,
    input  logic [TW-1:0] hdr_dts,
    input  logic          hdr_dts_vld,
    input  logic          hdr_is_av,
    input  logic          pl_valid,
    input  logic [DW-1:0] pl_data,
    input  logic          pl_last,
    output logic          hdr_match,
    output logic          dec_valid,
    output logic [DW-1:0] dec_data,
    output logic          buf_valid,
    output logic [DW-1:0] buf_data,
    output logic          eop_irq
);
    localparam int NMASK  = 2;
    localparam int NRANGE = 2;

    logic [FW-1:0] mk_field [NMASK];
    logic [FW-1:0] mk_match [NMASK];
    logic [FW-1:0] mk_mask  [NMASK];
    logic          mk_en    [NMASK];
    logic          mk_pres  [NMASK];
    logic          mk_pass  [NMASK];

    logic [TW-1:0] rg_val   [NRANGE];
    logic [TW-1:0] rg_lo    [NRANGE];
    logic [TW-1:0] rg_hi    [NRANGE];
    logic          rg_en    [NRANGE];
    logic          rg_pres  [NRANGE];
    logic          rg_pass  [NRANGE];

    logic [NUM_FILT-1:0] filt_res;
    logic                hdr_pass;

    always_comb begin
        mk_field[0] = hdr_flags;
        mk_match[0] = cfg_flag_match;
        mk_mask[0]  = cfg_flag_mask;
        mk_en[0]    = cfg_en[FI_FLAGS];
        mk_pres[0]  = 1'b1;
        mk_field[1] = hdr_trick;
        mk_match[1] = cfg_trick_match;
        mk_mask[1]  = cfg_trick_mask;
        mk_en[1]    = cfg_en[FI_TRICK];
        mk_pres[1]  = hdr_trick_vld;

        rg_val[0]  = hdr_pts;
        rg_lo[0]   = cfg_pts_lo;
        rg_hi[0]   = cfg_pts_hi;
        rg_en[0]   = cfg_en[FI_PTS];
        rg_pres[0] = hdr_pts_vld;
        rg_val[1]  = hdr_dts;
        rg_lo[1]   = cfg_dts_lo;
        rg_hi[1]   = cfg_dts_hi;
        rg_en[1]   = cfg_en[FI_DTS];
        rg_pres[1] = hdr_dts_vld;
    end

    for (genvar gi = 0; gi < NMASK; gi++) begin : g_mask
        pes_mask_cmp #(.W(FW)) u_mask (
            .field   (mk_field[gi]),
            .match   (mk_match[gi]),
            .mask    (mk_mask[gi]),
            .enable  (mk_en[gi]),
            .present (mk_pres[gi]),
            .pass    (mk_pass[gi])
        );
    end

    for (genvar gr = 0; gr < NRANGE; gr++) begin : g_range
        pes_range_cmp #(.W(TW)) u_range (
            .value   (rg_val[gr]),
            .lo      (rg_lo[gr]),
            .hi      (rg_hi[gr]),
            .enable  (rg_en[gr]),
            .present (rg_pres[gr]),
            .pass    (rg_pass[gr])
        );
    end

    always_comb begin
        filt_res[FI_FLAGS] = mk_pass[0];
        filt_res[FI_TRICK] = mk_pass[1];
        filt_res[FI_PTS]   = rg_pass[0];
        filt_res[FI_DTS]   = rg_pass[1];
        hdr_pass           = all_pass(filt_res);
    end

    pes_route #(.DW(DW)) u_route (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr_pass  (hdr_pass),
        .hdr_av    (hdr_is_av),
        .pl_valid  (pl_valid),
        .pl_data   (pl_data),
        .pl_last   (pl_last),
        .match_q   (hdr_match),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .buf_valid (buf_valid),
        .buf_data  (buf_data),
        .eop_irq   (eop_irq)
    );
endmodule

// File: rtl/pes_hdr_gate_chk.sv
module pes_hdr_gate_chk
    import pes_gate_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [3:0]            cfg_en,
    input logic [PES_BYTE_W-1:0] cfg_flag_match,
    input logic [PES_BYTE_W-1:0] cfg_flag_mask,
    input logic [PES_TS_W-1:0]   cfg_pts_lo,
    input logic [PES_TS_W-1:0]   cfg_dts_hi,
    input logic                  hdr_valid,
    input logic [PES_BYTE_W-1:0] hdr_flags,
    input logic [PES_TS_W-1:0]   hdr_pts,
    input logic                  hdr_pts_vld,
    input logic [PES_TS_W-1:0]   hdr_dts,
    input logic                  hdr_dts_vld,
    input logic                  hdr_match,
    input logic                  dec_valid,
    input logic                  buf_valid,
    input logic                  eop_irq
);
    // R1
    flag_miss_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && cfg_en[0] && (((hdr_flags ^ cfg_flag_match) & cfg_flag_mask) != '0))
        |=> !hdr_match);

    // R3
    pts_below_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && cfg_en[2] && hdr_pts_vld && (hdr_pts < cfg_pts_lo)) |=> !hdr_match);

    // R4
    dts_above_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && cfg_en[3] && hdr_dts_vld && (hdr_dts > cfg_dts_hi)) |=> !hdr_match);

    // R6
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> $stable(hdr_match));

    // R7
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_valid && buf_valid));

    // R9
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid || buf_valid) |-> $past(hdr_match));

    // R10
    irq_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        eop_irq |-> $past(dec_valid || buf_valid));
endmodule

bind pes_hdr_gate pes_hdr_gate_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_en         (cfg_en),
    .cfg_flag_match (cfg_flag_match),
    .cfg_flag_mask  (cfg_flag_mask),
    .cfg_pts_lo     (cfg_pts_lo),
    .cfg_dts_hi     (cfg_dts_hi),
    .hdr_valid      (hdr_valid),
    .hdr_flags      (hdr_flags),
    .hdr_pts        (hdr_pts),
    .hdr_pts_vld    (hdr_pts_vld),
    .hdr_dts        (hdr_dts),
    .hdr_dts_vld    (hdr_dts_vld),
    .hdr_match      (hdr_match),
    .dec_valid      (dec_valid),
    .buf_valid      (buf_valid),
    .eop_irq        (eop_irq)
);

// File: tb/pes_hdr_gate_tb_top.sv
`timescale 1ns/1ps
module pes_hdr_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_en = 4'hF;
    logic [7:0]  cfg_flag_match = 8'h80, cfg_flag_mask = 8'hC0;
    logic [7:0]  cfg_trick_match = 8'h00, cfg_trick_mask = 8'h00;
    logic [32:0] cfg_pts_lo = 33'd1000, cfg_pts_hi = 33'd2000;
    logic [32:0] cfg_dts_lo = 33'd500,  cfg_dts_hi = 33'd1500;
    logic        hdr_valid = 0, hdr_trick_vld = 0, hdr_pts_vld = 0, hdr_dts_vld = 0, hdr_is_av = 0;
    logic [7:0]  hdr_flags = 0, hdr_trick = 0;
    logic [32:0] hdr_pts = 0, hdr_dts = 0;
    logic        pl_valid = 0, pl_last = 0;
    logic [7:0]  pl_data = 0;
    logic        hdr_match, dec_valid, buf_valid, eop_irq;
    logic [7:0]  dec_data, buf_data;

    pes_hdr_gate dut_i (.*);

    always #2.5 clk = ~clk;

    typedef struct { bit to_dec; bit [7:0] data; bit last; } exp_t;
    exp_t exp_q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   pending_irq = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit model(input [7:0] fl, input [7:0] tr, input bit tv,
                                 input [32:0] p, input bit pv, input [32:0] d, input bit dv);
        bit f0, f1, f2, f3;
        f0 = !cfg_en[0] || (((fl ^ cfg_flag_match) & cfg_flag_mask) == 0);
        f1 = !cfg_en[1] || !tv || (((tr ^ cfg_trick_match) & cfg_trick_mask) == 0);
        f2 = !cfg_en[2] || !pv || (p >= cfg_pts_lo && p <= cfg_pts_hi);
        f3 = !cfg_en[3] || !dv || (d >= cfg_dts_lo && d <= cfg_dts_hi);
        return f0 && f1 && f2 && f3;
    endfunction

    // driver
    task automatic send(input string req, input [7:0] fl, input [7:0] tr, input bit tv,
                        input [32:0] p, input bit pv, input [32:0] d, input bit dv,
                        input bit av, input int n, input bit want);
        bit m;
        m = model(fl, tr, tv, p, pv, d, dv);
        chk(m == want, req, "model vs intent", m, want);
        @(negedge clk);
        hdr_valid = 1; hdr_flags = fl; hdr_trick = tr; hdr_trick_vld = tv;
        hdr_pts = p; hdr_pts_vld = pv; hdr_dts = d; hdr_dts_vld = dv; hdr_is_av = av;
        @(negedge clk);
        hdr_valid = 0;
        chk(hdr_match == want, req, "hdr_match", hdr_match, want);
        for (int i = 0; i < n; i++) begin
            pl_valid = 1; pl_data = 8'(p[7:0] + i * 37 + 5); pl_last = (i == n - 1);
            if (want) exp_q.push_back('{to_dec: av, data: pl_data, last: pl_last});
            @(negedge clk);
        end
        pl_valid = 0; pl_last = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            exp_t e;
            if (eop_irq || pending_irq)
                chk(eop_irq == pending_irq, "R10", "eop_irq", eop_irq, pending_irq);
            pending_irq = 0;
            if (dec_valid && buf_valid)
                chk(0, "R7", "both ports valid", 1, 0);
            if (dec_valid || buf_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected output byte", dec_valid ? dec_data : buf_data, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(dec_valid == e.to_dec, e.to_dec ? "R7" : "R8", "port dec_valid", dec_valid, e.to_dec);
                    chk((e.to_dec ? dec_data : buf_data) == e.data, e.to_dec ? "R7" : "R8", "data",
                        e.to_dec ? dec_data : buf_data, e.data);
                    pending_irq = e.last;
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(hdr_match == 0 && dec_valid == 0 && buf_valid == 0 && eop_irq == 0, "R11",
            "outputs in reset", {hdr_match, dec_valid, buf_valid, eop_irq}, 0);
        rst = 0;
        @(negedge clk);
        chk(hdr_match == 0, "R11", "decision after reset", hdr_match, 0);
        // R11: payload before any header is dropped
        for (int i = 0; i < 3; i++) begin
            pl_valid = 1; pl_data = 8'(i + 1); pl_last = (i == 2);
            @(negedge clk);
        end
        pl_valid = 0; pl_last = 0;
        idle(3);

        // R3 bounds, R7/R8 routing
        send("R7", 8'h80, 0, 0, 33'd1000, 1, 33'd600, 1, 1, 4, 1);
        send("R8", 8'h80, 0, 0, 33'd2000, 1, 33'd600, 1, 0, 3, 1);
        send("R3", 8'h80, 0, 0, 33'd999,  1, 33'd600, 1, 1, 3, 0);
        send("R3", 8'h80, 0, 0, 33'd2001, 1, 33'd600, 1, 0, 3, 0);
        send("R3", 8'h80, 0, 0, 33'd5,    0, 33'd600, 1, 0, 2, 1);
        // R4 bounds
        send("R4", 8'h80, 0, 0, 33'd1500, 1, 33'd499,  1, 1, 2, 0);
        send("R4", 8'h80, 0, 0, 33'd1500, 1, 33'd500,  1, 1, 2, 1);
        send("R4", 8'h80, 0, 0, 33'd1500, 1, 33'd1500, 1, 0, 2, 1);
        send("R4", 8'h80, 0, 0, 33'd1500, 1, 33'd1501, 1, 0, 2, 0);
        send("R4", 8'h80, 0, 0, 33'd1500, 1, 33'd9,    0, 1, 2, 1);
        // R6: PTS passes, DTS fails -> drop
        send("R6", 8'h80, 0, 0, 33'd1200, 1, 33'd3000, 1, 1, 3, 0);
        // R1 masked flags
        send("R1", 8'hC0, 0, 0, 33'd1200, 1, 33'd600, 1, 1, 2, 0);
        send("R1", 8'h9F, 0, 0, 33'd1200, 1, 33'd600, 1, 0, 2, 1);
        // R2 trick
        cfg_trick_match = 8'h5A; cfg_trick_mask = 8'hFF;
        send("R2", 8'h80, 8'h5A, 1, 33'd1200, 1, 33'd600, 1, 1, 2, 1);
        send("R2", 8'h80, 8'h5B, 1, 33'd1200, 1, 33'd600, 1, 1, 2, 0);
        send("R2", 8'h80, 8'h00, 0, 33'd1200, 1, 33'd600, 1, 0, 2, 1);
        // R5 disabled filters ignore mismatching fields
        cfg_en = 4'h0;
        send("R5", 8'h3F, 8'h00, 1, 33'd0, 1, 33'd99999, 1, 1, 3, 1);
        cfg_en = 4'b0100;
        send("R5", 8'h3F, 8'h00, 1, 33'd1200, 1, 33'd99999, 1, 0, 2, 1);
        cfg_en = 4'hF;
        // R3 full 33-bit window
        cfg_pts_lo = 33'h1_0000_0000; cfg_pts_hi = 33'h1_FFFF_FFFF;
        send("R3", 8'h80, 8'h5A, 1, 33'h1_0000_0000, 1, 33'd600, 1, 1, 2, 1);
        send("R3", 8'h80, 8'h5A, 1, 33'h0_FFFF_FFFF, 1, 33'd600, 1, 1, 2, 0);
        send("R3", 8'h80, 8'h5A, 1, 33'h1_FFFF_FFFF, 1, 33'd600, 1, 0, 2, 1);
        // R10 back-to-back single-byte packets with a drop between
        send("R10", 8'h80, 8'h5A, 1, 33'h1_0000_0001, 1, 33'd600, 1, 1, 1, 1);
        send("R10", 8'h80, 8'h5A, 1, 33'h1_0000_0002, 1, 33'd600, 1, 0, 1, 1);
        send("R9",  8'hC0, 8'h5A, 1, 33'h1_0000_0003, 1, 33'd600, 1, 0, 1, 0);
        send("R10", 8'h80, 8'h5A, 1, 33'h1_0000_0004, 1, 33'd600, 1, 1, 1, 1);
        idle(6);
        chk(exp_q.size() == 0, "R9", "expected bytes left", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule